// File: doc/BRIEF.md
# DMA Page-Table Address Translator

The translator maps a 32-bit address issued by a DMA-capable device onto a physical memory address. It walks a flat, single-level table that lives in main memory. Software sets two values through a small write port: where the table starts and how many bytes it covers. Each entry occupies 8 bytes. The first 32-bit word of an entry holds the physical frame, and the second word is never read.

A request is taken with a valid/ready handshake. Only one walk is in flight at a time. The block splits the address into a 4 KiB page index and an in-page offset, then checks the index against the table size. An index inside the table causes one 32-bit read of the frame word over a simple read port. An index outside the table, or a read that comes back with an error, ends the walk as a fault. Every walk finishes with a one-cycle done pulse that carries the translated address and a read/write permission bit.

Top module: `pt_xlate`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_done_o is 0 and mem_rd_valid_o is 0. Base and size both reset to 0, so every lookup faults until they are programmed.
- R2: The page index is req_addr_i[31:12]. The frame-word read goes to the base with bit 31 cleared, plus index times 8, wrapping modulo 2^32.
- R3: A lookup is in range only when index < (size >> 3). An out-of-range lookup issues no memory read and completes as a fault.
- R4: On a successful read, rsp_addr_o is {mem_rdata_i[31:12], req_addr_i[11:0]} and rsp_perm_o is 1 (read/write granted).
- R5: A fault returns rsp_addr_o = 0 and rsp_perm_o = 0. When mem_rerr_i is high, it overrides mem_rvalid_i.
- R6: req_ready_o is 0 from the cycle after acceptance through the done cycle. No second request is taken while a walk is open.
- R7: rsp_done_o is high for exactly one cycle per walk. rsp_addr_o and rsp_perm_o hold their values between done pulses.
- R8: mem_rd_valid_o stays high with a stable mem_rd_addr_o until mem_rvalid_i or mem_rerr_i is seen.
- R9: The size and base registers are written when cfg_we_i is 1; cfg_sel_i = 0 selects the base and cfg_sel_i = 1 selects the size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 = table base, 1 = table size in bytes |
| cfg_wdata_i | input | 32 | Configuration write data |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Translator idle and able to take a request |
| req_addr_i | input | 32 | Device-side address to translate |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_addr_o | output | 32 | Translated physical address, 0 on fault |
| rsp_perm_o | output | 1 | 1 = read/write granted, 0 = no access |
| mem_rd_valid_o | output | 1 | Frame-word read request |
| mem_rd_addr_o | output | 32 | Byte address of the frame word |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rerr_i | input | 1 | Read error response |
| mem_rdata_i | input | 32 | Read data (frame word) |

## Verification
The hardest case to reach is a walk whose index is in range but whose entry read fails. Only the memory side can produce it, and it has to happen while a later request is already waiting at the request port. The bench's memory responder takes a per-walk error flag and a per-walk latency. The driver keeps the next request asserted while a read is still outstanding. This checks that the fault zeroes the address, that the queued request is held off, and that the boundary indexes at size/8 - 1 and size/8 land on opposite sides of the range check, including a size that is not a multiple of 8.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DONE  = 2'd2
  } walk_state_e;
endpackage

// File: rtl/pt_xlate_regs.sv
module pt_xlate_regs #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          sel_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] size_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      size_o <= '0;
    end else if (we_i) begin
      if (sel_i) size_o <= wdata_i;
      else       base_o <= wdata_i;
    end
  end
endmodule

// File: rtl/pt_xlate_index.sv
module pt_xlate_index #(
  parameter int AW  = 32,
  parameter int PB  = 12,
  parameter int EB  = 3
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] size_i,
  output logic          in_range_o,
  output logic [AW-1:0] entry_addr_o
);
  localparam int IW = AW - PB;
  localparam logic [AW-1:0] BASE_MASK = {1'b0, {(AW-1){1'b1}}};

  logic [IW-1:0] idx;
  logic [AW-1:0] idx_ext;
  logic [AW-1:0] n_entries;

  assign idx          = addr_i[AW-1:PB];
  assign idx_ext      = {{PB{1'b0}}, idx};
  assign n_entries    = size_i >> EB;
  assign in_range_o   = idx_ext < n_entries;
  assign entry_addr_o = (base_i & BASE_MASK) + (idx_ext << EB);
endmodule

// File: rtl/pt_xlate_walk.sv
module pt_xlate_walk
  import pt_xlate_pkg::*;
#(
  parameter int AW = 32,
  parameter int PB = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic          in_range_i,
  input  logic [AW-1:0] entry_addr_i,
  output logic          rsp_done_o,
  output logic [AW-1:0] rsp_addr_o,
  output logic          rsp_perm_o,
  output logic          mem_rd_valid_o,
  output logic [AW-1:0] mem_rd_addr_o,
  input  logic          mem_rvalid_i,
  input  logic          mem_rerr_i,
  input  logic [AW-1:0] mem_rdata_i
);
  walk_state_e   state_q;
  logic [PB-1:0] off_q;
  logic [AW-1:0] mem_addr_q;
  logic [AW-1:0] rsp_addr_q;
  logic          rsp_perm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      off_q      <= '0;
      mem_addr_q <= '0;
      rsp_addr_q <= '0;
      rsp_perm_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          off_q <= req_addr_i[PB-1:0];
          if (in_range_i) begin
            mem_addr_q <= entry_addr_i;
            state_q    <= ST_FETCH;
          end else begin
            rsp_addr_q <= '0;
            rsp_perm_q <= 1'b0;
            state_q    <= ST_DONE;
          end
        end
        ST_FETCH: begin
          // error wins over data
          if (mem_rerr_i) begin
            rsp_addr_q <= '0;
            rsp_perm_q <= 1'b0;
            state_q    <= ST_DONE;
          end else if (mem_rvalid_i) begin
            rsp_addr_q <= {mem_rdata_i[AW-1:PB], off_q};
            rsp_perm_q <= 1'b1;
            state_q    <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o    = (state_q == ST_IDLE);
  assign mem_rd_valid_o = (state_q == ST_FETCH);
  assign mem_rd_addr_o  = mem_addr_q;
  assign rsp_done_o     = (state_q == ST_DONE);
  assign rsp_addr_o     = rsp_addr_q;
  assign rsp_perm_o     = rsp_perm_q;

  assert_idle_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mem_rd_valid_o && !rsp_done_o));
  assert_accept_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);
  assert_rsp_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_done_o |=> (rsp_done_o || ($stable(rsp_addr_o) && $stable(rsp_perm_o))));
  assert_fault_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_done_o && !rsp_perm_o) |-> (rsp_addr_o == '0));
  assert_rd_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_valid_o && !mem_rvalid_i && !mem_rerr_i) |=>
      (mem_rd_valid_o && $stable(mem_rd_addr_o)));
  assert_err_fault_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_valid_o && mem_rerr_i) |=> (rsp_done_o && !rsp_perm_o));
endmodule

// File: rtl/pt_xlate.sv
module pt_xlate #(
  parameter int AW = 32,
  parameter int PB = 12,
  parameter int EB = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          cfg_sel_i,
  input  logic [AW-1:0] cfg_wdata_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  output logic          rsp_done_o,
  output logic [AW-1:0] rsp_addr_o,
  output logic          rsp_perm_o,
  output logic          mem_rd_valid_o,
  output logic [AW-1:0] mem_rd_addr_o,
  input  logic          mem_rvalid_i,
  input  logic          mem_rerr_i,
  input  logic [AW-1:0] mem_rdata_i
);
  logic [AW-1:0] base, size, entry_addr;
  logic          in_range;

  pt_xlate_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .base_o(base), .size_o(size)
  );

  pt_xlate_index #(.AW(AW), .PB(PB), .EB(EB)) u_index (
    .addr_i(req_addr_i), .base_i(base), .size_i(size),
    .in_range_o(in_range), .entry_addr_o(entry_addr)
  );

  pt_xlate_walk #(.AW(AW), .PB(PB)) u_walk (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_addr_i,
    .in_range_i(in_range), .entry_addr_i(entry_addr),
    .rsp_done_o, .rsp_addr_o, .rsp_perm_o,
    .mem_rd_valid_o, .mem_rd_addr_o,
    .mem_rvalid_i, .mem_rerr_i, .mem_rdata_i
  );
endmodule

// File: tb/pt_xlate_test.sv
module pt_xlate_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0, cfg_sel_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_addr_i = '0;
  logic        rsp_done_o, rsp_perm_o, mem_rd_valid_o;
  logic [31:0] rsp_addr_o, mem_rd_addr_o;
  logic        mem_rvalid_i = 1'b0, mem_rerr_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  pt_xlate uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, fails = 0;
  logic [31:0] m_base = '0, m_size = '0;

  typedef struct packed { logic [31:0] addr; logic perm; } rsp_t;
  typedef struct packed { logic [31:0] addr; logic [31:0] frame; logic err; logic [3:0] lat; } rd_t;
  rsp_t rsp_q[$];
  rd_t  rd_q[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (sel) m_size = d; else m_base = d;
  endtask

  // driver: computes expectation, pushes, presents request until taken
  task automatic lookup(input logic [31:0] a, input logic [31:0] frame, input logic err, input logic [3:0] lat);
    logic [31:0] idx;
    rsp_t r;
    rd_t  m;
    idx = {12'd0, a[31:12]};
    if (idx < (m_size >> 3)) begin
      m.addr  = (m_base & 32'h7fff_ffff) + (idx << 3);
      m.frame = frame; m.err = err; m.lat = lat;
      rd_q.push_back(m);
      r.addr = err ? 32'd0 : {frame[31:12], a[11:0]};
      r.perm = !err;
    end else begin
      r.addr = '0; r.perm = 1'b0;
    end
    rsp_q.push_back(r);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a;
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk_i);
      if (mem_rd_valid_o) begin
        rd_t m;
        if (rd_q.size() == 0) begin
          check(1'b0, "R3 unexpected read", mem_rd_addr_o, 32'hx);
          mem_rerr_i = 1'b1;
          @(negedge clk_i);
          mem_rerr_i = 1'b0;
        end else begin
          m = rd_q.pop_front();
          check(mem_rd_addr_o == m.addr, "R2 entry address", mem_rd_addr_o, m.addr);
          check(!req_ready_o, "R6 ready low during walk", {31'd0, req_ready_o}, 32'd0);
          for (int i = 0; i < m.lat; i++) begin
            @(negedge clk_i);
            check(mem_rd_valid_o && mem_rd_addr_o == m.addr, "R8 read held",
                  mem_rd_addr_o, m.addr);
          end
          mem_rdata_i = m.frame | 32'h0000_0fff;  // low bits must be dropped
          mem_rdata_i[31:12] = m.frame[31:12];
          mem_rerr_i  = m.err;
          mem_rvalid_i = 1'b1;
          @(negedge clk_i);
          mem_rvalid_i = 1'b0; mem_rerr_i = 1'b0;
        end
      end
    end
  end

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (rsp_done_o) begin
        rsp_t e;
        logic [31:0] held;
        e = rsp_q.pop_front();
        check(rsp_addr_o == e.addr, "R4/R5 address", rsp_addr_o, e.addr);
        check(rsp_perm_o == e.perm, "R4/R5 perm", {31'd0, rsp_perm_o}, {31'd0, e.perm});
        held = rsp_addr_o;
        @(negedge clk_i);
        check(!rsp_done_o, "R7 done one cycle", {31'd0, rsp_done_o}, 32'd0);
        check(rsp_addr_o == held, "R7 response held", rsp_addr_o, held);
      end
    end
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(req_ready_o && !rsp_done_o && !mem_rd_valid_o, "R1 reset state",
          {29'd0, req_ready_o, rsp_done_o, mem_rd_valid_o}, 32'd4);
    lookup(32'h0000_0123, 32'h0, 1'b0, 4'd0);      // R1: faults before programming
    // R9: base with bit 31 set (must be cleared), 8 entries
    cfg_write(1'b0, 32'h8001_0000);
    cfg_write(1'b1, 32'h0000_0040);
    lookup(32'h0000_0abc, 32'h1234_5000, 1'b0, 4'd0);  // R4 index 0
    lookup(32'h0000_7fff, 32'hABCD_E000, 1'b0, 4'd3);  // R2/R8 last in-range index
    lookup(32'h0000_8000, 32'h0, 1'b0, 4'd0);          // R3 first out-of-range
    lookup(32'hFFFF_F001, 32'h0, 1'b0, 4'd0);          // R3 far out
    lookup(32'h0000_3456, 32'h7777_7000, 1'b1, 4'd2);  // R5 error response
    lookup(32'h0000_2001, 32'h0000_1000, 1'b0, 4'd5);  // R8 long latency
    cfg_write(1'b1, 32'h0000_0047);                    // R3 non-multiple of 8
    lookup(32'h0000_8010, 32'h0, 1'b0, 4'd0);
    lookup(32'h0000_7010, 32'hFEED_F000, 1'b0, 4'd1);
    cfg_write(1'b0, 32'h0000_2008);                    // R9 new base
    cfg_write(1'b1, 32'h0010_0000);
    lookup(32'h0123_4567, 32'h5555_A000, 1'b0, 4'd0);
    lookup(32'h0123_4568, 32'h0, 1'b1, 4'd0);          // R5 immediate error
    while (rsp_q.size() != 0 || rd_q.size() != 0) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule